// File: doc/BRIEF.md
# Queued Invalidation Descriptor Engine

This block runs a circular queue of 128-bit invalidation commands that software keeps in system memory. Software programs the queue's base and size, turns the queue on through a global command bit, and then writes a new tail offset. The engine fetches each descriptor in turn and executes it, and it moves its head offset forward as it goes. It stops when the head catches up with the tail.

The design holds no translation caches. Context-cache, IOTLB and interrupt-entry-cache invalidations therefore retire at once and have no effect. A wait descriptor can write a 32-bit status word back to memory and can raise a completion message. The message goes out on an address/data output. It has its own mask bit, and a pending flag records any message that arrived while the mask was set. An unrecognised descriptor stops the queue with an error flag, and software clears that flag to resume.

The state machine has five states. IDLE waits for work. FETCH reads a descriptor. EXEC decodes it. STATUS writes the wait status word. NOTIFY raises the completion message. The transitions are as follows:
- IDLE to FETCH when the queue is on, no error is set and head differs from tail.
- FETCH to EXEC on the memory acknowledge.
- EXEC to IDLE for a cache invalidation, for a wait descriptor with no flags, or for an unknown type.
- EXEC to STATUS for a wait descriptor with the status flag set.
- EXEC to NOTIFY for a wait descriptor with only the interrupt flag set.
- STATUS to NOTIFY on the acknowledge when the interrupt flag is set, and STATUS to IDLE otherwise.
- NOTIFY to IDLE always.

Top module: `inv_queue_engine`

## Requirements
- R1: After reset the queue is off, head is 0, the error and pending flags are clear, and no memory request or message is active.
- R2: Writing select 0 with data bit 0 = 1 turns the queue on. The enabled output rises within a few cycles and head is cleared to 0. Writing bit 0 = 0 drops the enabled output once the engine is idle.
- R3: Nothing is fetched while the queue is off. Once it is on, each descriptor is read with one 128-bit read at base + head. Processing continues until head equals tail, where tail is written through select 2 as a byte offset with bits 3:0 ignored.
- R4: Head advances by 16 bytes per descriptor and wraps at 16 << (MIN_LOG + qsz) bytes. Select 1 gives the base in data bits PAW-1:12 and qsz in data bits 2:0.
- R5: Descriptor types 1 (context cache), 2 (IOTLB) and 4 (interrupt entry cache) sit in bits 3:0. They retire with no memory write and no message.
- R6: Type 5 (wait) with bit 5 set writes bits 63:32 of the descriptor to the address in bits 127:66 shifted left by 2. Bits 65:64 are ignored.
- R7: A wait descriptor with bit 4 set, while the mask is clear, sends one message. The message address comes from select 5 and the data from select 4.
- R8: When the mask (select 3, bit 0) is set at the moment a message would fire, the pending flag is set and no message goes out. Clearing the mask then sends exactly one message and clears the pending flag.
- R9: Any other type sets the error output and leaves head on that descriptor, and nothing more is fetched. Writing select 6 with bit 0 = 1 clears the error, and the engine then refetches that descriptor.
- R10: A memory request holds its address and direction until it is acknowledged, and each descriptor is fetched exactly once.
- R11: A wait descriptor with both flags set performs its status write before it sends its message.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select (0 command, 1 queue address, 2 tail, 3 mask, 4 msg data, 5 msg address, 6 error clear) |
| reg_wdata | input | 64 | Register write data |
| q_enabled | output | 1 | Queue enable status |
| q_head | output | MIN_LOG+11 | Head byte offset |
| q_error | output | 1 | Unknown descriptor error |
| cmpl_pending | output | 1 | Completion message pending under mask |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | PAW | Memory byte address |
| mem_wdata | output | 32 | Status write data |
| mem_rdata | input | 128 | Descriptor read data |
| mem_ack | input | 1 | Memory acknowledge |
| msg_valid | output | 1 | Completion message strobe |
| msg_addr | output | 32 | Completion message address |
| msg_data | output | 32 | Completion message data |

## Verification
A register write takes effect at the next clock edge, and the engine sees the new tail one cycle later. A descriptor then takes one cycle to request and one cycle to acknowledge. It takes one EXEC cycle after that, plus two cycles for a status write and one for NOTIFY. The message strobe follows NOTIFY, or a mask-clearing write, by one registered cycle. The bench does not count these chains for each case. It polls head on falling edges until head reaches the written tail, with a bound, and then waits four more falling edges before it reads the write and message logs, so every due result has settled. Error and enable checks use a fixed wait that is longer than the longest chain.

// File: rtl/qi_pkg.sv
package qi_pkg;
    typedef enum logic [2:0] {
        SEL_GCMD  = 3'd0,
        SEL_QADDR = 3'd1,
        SEL_TAIL  = 3'd2,
        SEL_CCTL  = 3'd3,
        SEL_CDATA = 3'd4,
        SEL_CADDR = 3'd5,
        SEL_FSTS  = 3'd6
    } qi_reg_e;

    typedef enum logic [3:0] {
        DSC_CTX   = 4'd1,
        DSC_IOTLB = 4'd2,
        DSC_IEC   = 4'd4,
        DSC_WAIT  = 4'd5
    } qi_dsc_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_EXEC,
        ST_STATUS,
        ST_NOTIFY
    } qi_state_e;

    localparam int FLAG_IRQ = 4;
    localparam int FLAG_STS = 5;
    localparam int SIZE_SPAN = 7;
endpackage

// File: rtl/qi_regs.sv
module qi_regs
    import qi_pkg::*;
#(
    parameter int PAW   = 48,
    parameter int OFF_W = 19
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  qi_reg_e              wr_sel,
    input  logic [63:0]          wr_data,
    input  logic                 notify,
    input  logic                 err_set,
    output logic                 en_req,
    output logic [PAW-13:0]      qbase,
    output logic [2:0]           qsz,
    output logic [OFF_W-1:0]     tail_off,
    output logic                 err,
    output logic                 ip,
    output logic                 msg_valid,
    output logic [31:0]          msg_addr,
    output logic [31:0]          msg_data
);
    logic cmask;
    logic mask_nxt;
    logic send;
    logic unused_wd;

    assign unused_wd = ^wr_data;

    // Mask value seen this cycle includes a same-cycle write to it.
    always_comb begin
        mask_nxt = (wr_en && wr_sel == SEL_CCTL) ? wr_data[0] : cmask;
        send     = !mask_nxt && (ip || notify);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_req    <= 1'b0;
            qbase     <= '0;
            qsz       <= '0;
            tail_off  <= '0;
            cmask     <= 1'b0;
            msg_addr  <= '0;
            msg_data  <= '0;
            err       <= 1'b0;
            ip        <= 1'b0;
            msg_valid <= 1'b0;
        end else begin
            cmask     <= mask_nxt;
            ip        <= mask_nxt && (ip || notify);
            msg_valid <= send;
            if (err_set) begin
                err <= 1'b1;
            end else if (wr_en && wr_sel == SEL_FSTS && wr_data[0]) begin
                err <= 1'b0;
            end
            if (wr_en) begin
                case (wr_sel)
                    SEL_GCMD:  en_req   <= wr_data[0];
                    SEL_QADDR: begin
                        qbase <= wr_data[PAW-1:12];
                        qsz   <= wr_data[2:0];
                    end
                    SEL_TAIL:  tail_off <= {wr_data[OFF_W-1:4], 4'b0000};
                    SEL_CDATA: msg_data <= wr_data[31:0];
                    SEL_CADDR: msg_addr <= wr_data[31:0];
                    default:   ;
                endcase
            end
        end
    end
endmodule

// File: rtl/qi_fsm.sv
module qi_fsm
    import qi_pkg::*;
#(
    parameter int PAW     = 48,
    parameter int MIN_LOG = 8,
    parameter int OFF_W   = 19
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_req,
    input  logic [PAW-13:0]   qbase,
    input  logic [2:0]        qsz,
    input  logic [OFF_W-1:0]  tail_off,
    input  logic              err,
    input  logic              mem_ack,
    input  logic [127:0]      mem_rdata,
    output logic              en_sts,
    output logic [OFF_W-1:0]  head,
    output logic              mem_req,
    output logic              mem_we,
    output logic [PAW-1:0]    mem_addr,
    output logic [31:0]       mem_wdata,
    output logic              notify,
    output logic              err_set
);
    localparam logic [2:0] SPAN_L = 3'(OFF_W - 4 - MIN_LOG);

    qi_state_e        state;
    logic [127:0]     desc;
    qi_dsc_e          dtype;
    logic             known;
    logic [OFF_W-1:0] qmask;
    logic [OFF_W-1:0] head_inc;
    logic [OFF_W-1:0] tail_m;
    logic [PAW-1:0]   fetch_addr;
    logic [PAW-1:0]   stat_addr;
    logic             unused_desc;

    assign unused_desc = ^{desc[31:6], desc[65:64], desc[127:64+PAW]};

    always_comb begin
        qmask      = {OFF_W{1'b1}} >> (SPAN_L - qsz);
        head_inc   = (head + OFF_W'(16)) & qmask;
        tail_m     = tail_off & qmask;
        fetch_addr = {qbase, 12'h000} + PAW'(head);
        stat_addr  = {desc[64+PAW-1:66], 2'b00};
        dtype      = qi_dsc_e'(desc[3:0]);
        known      = (dtype == DSC_CTX) || (dtype == DSC_IOTLB) ||
                     (dtype == DSC_IEC) || (dtype == DSC_WAIT);
    end

    // State register, head pointer and enable handshake
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            head   <= '0;
            en_sts <= 1'b0;
            desc   <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (en_req && !en_sts) begin
                        en_sts <= 1'b1;
                        head   <= '0;
                    end else if (!en_req && en_sts) begin
                        en_sts <= 1'b0;
                    end else if (en_sts && !err && head != tail_m) begin
                        state <= ST_FETCH;
                    end
                end
                ST_FETCH: begin
                    if (mem_ack) begin
                        desc  <= mem_rdata;
                        state <= ST_EXEC;
                    end
                end
                ST_EXEC: begin
                    case (dtype)
                        DSC_CTX, DSC_IOTLB, DSC_IEC: begin
                            head  <= head_inc;
                            state <= ST_IDLE;
                        end
                        DSC_WAIT: begin
                            if (desc[FLAG_STS]) begin
                                state <= ST_STATUS;
                            end else if (desc[FLAG_IRQ]) begin
                                state <= ST_NOTIFY;
                            end else begin
                                head  <= head_inc;
                                state <= ST_IDLE;
                            end
                        end
                        default: state <= ST_IDLE;
                    endcase
                end
                ST_STATUS: begin
                    if (mem_ack) begin
                        if (desc[FLAG_IRQ]) begin
                            state <= ST_NOTIFY;
                        end else begin
                            head  <= head_inc;
                            state <= ST_IDLE;
                        end
                    end
                end
                ST_NOTIFY: begin
                    head  <= head_inc;
                    state <= ST_IDLE;
                end
            endcase
        end
    end

    // Outputs decoded from the current state
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        notify    = 1'b0;
        err_set   = 1'b0;
        unique case (state)
            ST_IDLE:   ;
            ST_FETCH: begin
                mem_req  = 1'b1;
                mem_addr = fetch_addr;
            end
            ST_EXEC:   err_set = !known;
            ST_STATUS: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = stat_addr;
                mem_wdata = desc[63:32];
            end
            ST_NOTIFY: notify = 1'b1;
        endcase
    end
endmodule

// File: rtl/inv_queue_engine.sv
module inv_queue_engine
    import qi_pkg::*;
#(
    parameter int PAW     = 48,
    parameter int MIN_LOG = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  reg_wr_en,
    input  logic [2:0]            reg_sel,
    input  logic [63:0]           reg_wdata,
    output logic                  q_enabled,
    output logic [MIN_LOG+10:0]   q_head,
    output logic                  q_error,
    output logic                  cmpl_pending,
    output logic                  mem_req,
    output logic                  mem_we,
    output logic [PAW-1:0]        mem_addr,
    output logic [31:0]           mem_wdata,
    input  logic [127:0]          mem_rdata,
    input  logic                  mem_ack,
    output logic                  msg_valid,
    output logic [31:0]           msg_addr,
    output logic [31:0]           msg_data
);
    localparam int OFF_W = 4 + MIN_LOG + SIZE_SPAN;

    logic              en_req;
    logic [PAW-13:0]   qbase;
    logic [2:0]        qsz;
    logic [OFF_W-1:0]  tail_off;
    logic              notify;
    logic              err_set;

    qi_regs #(.PAW(PAW), .OFF_W(OFF_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (reg_wr_en),
        .wr_sel    (qi_reg_e'(reg_sel)),
        .wr_data   (reg_wdata),
        .notify    (notify),
        .err_set   (err_set),
        .en_req    (en_req),
        .qbase     (qbase),
        .qsz       (qsz),
        .tail_off  (tail_off),
        .err       (q_error),
        .ip        (cmpl_pending),
        .msg_valid (msg_valid),
        .msg_addr  (msg_addr),
        .msg_data  (msg_data)
    );

    qi_fsm #(.PAW(PAW), .MIN_LOG(MIN_LOG), .OFF_W(OFF_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_req    (en_req),
        .qbase     (qbase),
        .qsz       (qsz),
        .tail_off  (tail_off),
        .err       (q_error),
        .mem_ack   (mem_ack),
        .mem_rdata (mem_rdata),
        .en_sts    (q_enabled),
        .head      (q_head),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .notify    (notify),
        .err_set   (err_set)
    );
endmodule

// File: rtl/qi_chk.sv
module qi_chk #(
    parameter int PAW = 48,
    parameter int HW  = 19
) (
    input logic           clk,
    input logic           rst_n,
    input logic           mem_req,
    input logic           mem_ack,
    input logic           mem_we,
    input logic [PAW-1:0] mem_addr,
    input logic           msg_valid,
    input logic           ip,
    input logic           err,
    input logic [HW-1:0]  head,
    input logic           en_req,
    input logic           en_sts
);
    // R10
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req);

    // R10
    addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> $stable(mem_addr) && $stable(mem_we));

    // R8
    pend_msg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid |-> !ip);

    // R9
    err_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> $stable(head));

    // R9
    err_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> !mem_req);

    // R2
    en_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(en_sts) |-> $past(en_req) && head == '0);
endmodule

bind inv_queue_engine qi_chk #(.PAW(PAW), .HW(MIN_LOG + 11)) u_qi_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_req   (mem_req),
    .mem_ack   (mem_ack),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .msg_valid (msg_valid),
    .ip        (cmpl_pending),
    .err       (q_error),
    .head      (q_head),
    .en_req    (en_req),
    .en_sts    (q_enabled)
);

// File: tb/test_inv_queue_engine.sv
module test_inv_queue_engine;
    localparam int PAW = 32;
    localparam int ML  = 2;
    localparam int HW  = ML + 11;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic           rst_n = 1'b0;
    logic           reg_wr_en = 1'b0;
    logic [2:0]     reg_sel = '0;
    logic [63:0]    reg_wdata = '0;
    logic           q_enabled, q_error, cmpl_pending;
    logic [HW-1:0]  q_head;
    logic           mem_req, mem_we, mem_ack = 1'b0;
    logic [PAW-1:0] mem_addr;
    logic [31:0]    mem_wdata;
    logic [127:0]   mem_rdata = '0;
    logic           msg_valid;
    logic [31:0]    msg_addr, msg_data;

    inv_queue_engine #(.PAW(PAW), .MIN_LOG(ML)) i_inv_queue_engine (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .q_enabled(q_enabled), .q_head(q_head),
        .q_error(q_error), .cmpl_pending(cmpl_pending), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ack(mem_ack), .msg_valid(msg_valid),
        .msg_addr(msg_addr), .msg_data(msg_data)
    );

    logic [127:0] qmem [0:63];
    int fetch_cnt = 0, wr_cnt = 0, msg_cnt = 0, cyc = 0;
    int wr_time = 0, msg_time = 0;
    logic [PAW-1:0] wr_addr = '0;
    logic [31:0] wr_data = '0, m_addr = '0, m_data = '0;

    always @(posedge clk) begin
        cyc     <= cyc + 1;
        mem_ack <= 1'b0;
        if (mem_req && !mem_ack) begin
            mem_ack <= 1'b1;
            if (mem_we) begin
                wr_cnt  <= wr_cnt + 1;
                wr_addr <= mem_addr;
                wr_data <= mem_wdata;
                wr_time <= cyc;
            end else begin
                fetch_cnt <= fetch_cnt + 1;
                mem_rdata <= qmem[mem_addr[9:4]];
            end
        end
        if (msg_valid) begin
            msg_cnt  <= msg_cnt + 1;
            m_addr   <= msg_addr;
            m_data   <= msg_data;
            msg_time <= cyc;
        end
    end

    int total = 0, bad = 0;
    bit done = 1'b0;

    task automatic chk(string req, string what, longint act, longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wreg(logic [2:0] s, logic [63:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1;
        reg_sel   = s;
        reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    function automatic logic [127:0] mk_wait(int n, bit sw, bit irq);
        logic [63:0] lo, hi;
        lo = {32'(32'hA000 + n), 26'd0, sw, irq, 4'd5};
        hi = 64'(32'h8000 + n * 8) | 64'h3;
        return {hi, lo};
    endfunction

    task automatic wait_head(int target);
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (int'(q_head) == target) break;
        end
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL R3 watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int exp_fetch, exp_wr, exp_msg, n, head_b, size, entries, k, kind;
        int last_wr_n, last_msg_n, last_kind, h;
        for (int i = 0; i < 64; i++) qmem[i] = '0;
        exp_fetch = 0; exp_wr = 0; exp_msg = 0; n = 0;
        last_wr_n = -1; last_msg_n = -1; last_kind = 0;

        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1", "enabled", q_enabled, 0);
        chk("R1", "head", q_head, 0);
        chk("R1", "error", q_error, 0);
        chk("R1", "pending", cmpl_pending, 0);
        chk("R1", "mem_req", mem_req, 0);
        chk("R1", "msg_valid", msg_valid, 0);
        rst_n = 1'b1;

        wreg(3'd5, 64'hFEE0_1000);
        wreg(3'd4, 64'h41);
        wreg(3'd3, 64'h0);
        wreg(3'd1, 64'h1000);
        qmem[0] = {124'd0, 4'd1};
        wreg(3'd2, 64'd16);
        repeat (20) @(negedge clk);
        // R3 no fetch while disabled
        chk("R3", "fetch while off", fetch_cnt, 0);
        wreg(3'd0, 64'h1);
        wait_head(16);
        exp_fetch = 1;
        chk("R2", "enabled", q_enabled, 1);
        chk("R5", "ctx head", q_head, 16);
        chk("R5", "ctx no write", wr_cnt, 0);
        chk("R5", "ctx no msg", msg_cnt, 0);

        head_b = 0;
        for (int qsz = 0; qsz < 2; qsz++) begin
            size = 16 << (ML + qsz);
            entries = size / 16;
            wreg(3'd0, 64'h0);
            repeat (4) @(negedge clk);
            chk("R2", "disabled", q_enabled, 0);
            wreg(3'd2, 64'h0);
            wreg(3'd1, 64'h1000 | 64'(qsz));
            wreg(3'd0, 64'h1);
            repeat (4) @(negedge clk);
            chk("R2", "enabled", q_enabled, 1);
            chk("R2", "head cleared", q_head, 0);
            head_b = 0;
            for (int r = 0; r < 3 * entries; r++) begin
                k = (r % 3) + 1;
                for (int j = 0; j < k; j++) begin
                    kind = n % 6;
                    case (kind)
                        0: qmem[(head_b / 16 + j) % entries] = {124'd0, 4'd1};
                        1: qmem[(head_b / 16 + j) % entries] = {124'd0, 4'd2};
                        2: qmem[(head_b / 16 + j) % entries] = {124'd0, 4'd4};
                        3: qmem[(head_b / 16 + j) % entries] = mk_wait(n, 1, 0);
                        4: qmem[(head_b / 16 + j) % entries] = mk_wait(n, 0, 1);
                        default: qmem[(head_b / 16 + j) % entries] = mk_wait(n, 1, 1);
                    endcase
                    exp_fetch++;
                    if (kind == 3 || kind == 5) begin exp_wr++; last_wr_n = n; end
                    if (kind == 4 || kind == 5) begin exp_msg++; last_msg_n = n; end
                    last_kind = kind;
                    n++;
                end
                head_b = (head_b + k * 16) % size;
                wreg(3'd2, 64'(head_b));
                wait_head(head_b);
                chk("R4", "head wrap", q_head, head_b);
                chk("R3", "fetches", fetch_cnt, exp_fetch);
                chk("R10", "single fetch", fetch_cnt, exp_fetch);
                chk("R5", "write count", wr_cnt, exp_wr);
                chk("R7", "msg count", msg_cnt, exp_msg);
                if (last_wr_n >= 0) begin
                    chk("R6", "status addr", wr_addr, 32'h8000 + last_wr_n * 8);
                    chk("R6", "status data", wr_data, 32'hA000 + last_wr_n);
                end
                if (last_msg_n >= 0) begin
                    chk("R7", "msg addr", m_addr, 32'hFEE0_1000);
                    chk("R7", "msg data", m_data, 32'h41);
                end
                if (last_kind == 5) chk("R11", "write before msg", wr_time < msg_time, 1);
            end
        end

        // R8 masked completion then unmask
        wreg(3'd3, 64'h1);
        qmem[head_b / 16] = mk_wait(n, 0, 1);
        n++;
        exp_fetch++;
        head_b = (head_b + 16) % 128;
        wreg(3'd2, 64'(head_b));
        wait_head(head_b);
        chk("R8", "no msg while masked", msg_cnt, exp_msg);
        chk("R8", "pending set", cmpl_pending, 1);
        wreg(3'd3, 64'h0);
        repeat (3) @(negedge clk);
        exp_msg++;
        chk("R8", "msg on unmask", msg_cnt, exp_msg);
        chk("R8", "pending clear", cmpl_pending, 0);

        // R9 unknown descriptor halts
        h = head_b;
        qmem[h / 16] = {124'd0, 4'd7};
        qmem[((h / 16) + 1) % 8] = {124'd0, 4'd2};
        head_b = (h + 32) % 128;
        wreg(3'd2, 64'(head_b));
        repeat (30) @(negedge clk);
        exp_fetch++;
        chk("R9", "error set", q_error, 1);
        chk("R9", "head held", q_head, h);
        chk("R9", "no further fetch", fetch_cnt, exp_fetch);
        qmem[h / 16] = {124'd0, 4'd1};
        wreg(3'd6, 64'h1);
        wait_head(head_b);
        exp_fetch += 2;
        chk("R9", "error cleared", q_error, 0);
        chk("R9", "resumed head", q_head, head_b);
        chk("R9", "refetch", fetch_cnt, exp_fetch);

        wreg(3'd0, 64'h0);
        repeat (4) @(negedge clk);
        chk("R2", "final disable", q_enabled, 0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule